// File: doc/BRIEF.md
# Flash Page Manager with Erase-Before-Write and Relocation

This block sits in front of a small flash array made of physical blocks, each holding a fixed number of pages. Clients issue whole-page read and write requests against logical blocks. The manager keeps a two-bit state for every physical page: erased = 00, valid = 01, stale = 10. It also keeps a small table that maps each logical block onto a physical block. A page can be programmed only while its state is erased. Reading a page that has never been programmed returns all-ones data.

When a client writes a page that already holds data, the manager cannot program it in place. It chooses a spare physical block and erases it. The erase is long: the flash interface stays busy for a configurable number of cycles. The manager then walks the old block page by page. It copies every valid page into the spare, puts the new data in place of the rewritten page, and marks the old pages stale. Finally it points the logical block at the new physical block, and the old block becomes a spare.

Every physical block has an erase counter. A block whose counter reaches the wear limit is retired: it is never again chosen as a spare. A rewrite that finds no usable spare is refused with an error, and the stored data is left untouched.

Top module: `fpm_page_manager`

## Requirements
- R1: Every request transfers exactly one full page of DATA_W bits. A read returns the whole word most recently written to that logical page, and the word survives any number of relocations of its block.
- R2: Every page index from 0 to PAGES_PER_BLK-1 is independently addressable in every logical block. PAGES_PER_BLK is a parameter in the range 32 to 128.
- R3: A write to a page whose state is erased (00) programs it directly to valid (01), with no erase and no error. Programming a page that is not erased never happens.
- R4: A write to a valid page relocates the block. The spare is erased, each other valid page is copied into the spare, and the new word is stored. Pages that were erased before the rewrite still read as erased afterwards.
- R5: Each erase raises flash_erase_o for one cycle, with the physical block number on flash_erase_blk_o. flash_busy_o then stays high for exactly ERASE_CYCLES consecutive cycles.
- R6: Each physical block counts its erases. Once a block's count reaches WEAR_LIMIT, the block is retired and is never erased or chosen as a spare again.
- R7: If a rewrite finds no spare that is both unmapped and not retired, it completes with err_o = 1. No erase is issued and no stored data changes.
- R8: A read of a page in the erased state returns all ones.
- R9: req_ready_o is high only while the manager is idle. Each accepted request yields one done_o pulse lasting one cycle. err_o is only ever high together with done_o.
- R10: After reset every page is erased, logical block i maps to physical block i, req_ready_o is high, and done_o and flash_busy_o are low.
- R11: The spare chosen for a relocation is the lowest-numbered physical block that is neither mapped to a logical block nor retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Manager can accept a request |
| req_write_i | input | 1 | 1 = page write, 0 = page read |
| req_lblk_i | input | LB_W | Logical block number |
| req_page_i | input | PG_W | Page index inside the block |
| req_wdata_i | input | DATA_W | Page data for writes |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request refused (no spare), valid with done_o |
| rdata_o | output | DATA_W | Read data, valid with done_o |
| flash_erase_o | output | 1 | Block erase command pulse |
| flash_erase_blk_o | output | PB_W | Physical block being erased |
| flash_busy_o | output | 1 | Flash interface busy with an erase |

## Verification
The bench sweeps all 32 pages of every logical block, before and after the first writes. An address decode error would return wrong or all-ones words, and a failure to treat untouched pages as erased would return stale data. It then rewrites one page over and over, so the spare alternates between two physical blocks until both wear out. A design that copied pages badly would lose neighbouring words or revive pages that were erased. Retiring a block late would erase it past its limit, and retiring it early would refuse a rewrite too soon. A wrong spare choice shows up as a wrong block number on the erase port, and a wrong erase timer as a wrong count of busy cycles. Once no spare is left, a rewrite must fail without disturbing data in either logical block. Writes to erased pages must still succeed in a block that is already retired.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        PG_ERASED = 2'b00,
        PG_VALID  = 2'b01,
        PG_STALE  = 2'b10
    } page_state_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_ERASE,
        ST_COPY,
        ST_FINISH
    } fsm_e;

endpackage

// File: rtl/fpm_page_store.sv
module fpm_page_store #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) cells_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells_q[raddr_i];
endmodule

// File: rtl/fpm_erase_timer.sv
module fpm_erase_timer #(
    parameter int ERASE_CYCLES = 50000,
    localparam int CW = $clog2(ERASE_CYCLES)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic busy_o,
    output logic fin_o
);
    logic [CW-1:0] cnt_q;
    logic          busy_q;

    assign fin_o  = busy_q && (cnt_q == CW'(ERASE_CYCLES - 1));
    assign busy_o = busy_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (fin_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_q && !fin_o |=> busy_q); // R5
    AST_START_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |-> !busy_q); // R5
endmodule

// File: rtl/fpm_wear_track.sv
module fpm_wear_track #(
    parameter int NUM_PBLK   = 4,
    parameter int WEAR_LIMIT = 100000,
    localparam int PB_W = $clog2(NUM_PBLK),
    localparam int CW   = $clog2(WEAR_LIMIT + 1)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                inc_i,
    input  logic [PB_W-1:0]     blk_i,
    output logic [NUM_PBLK-1:0] bad_o
);
    logic [CW-1:0] cnt_q [NUM_PBLK];

    for (genvar g = 0; g < NUM_PBLK; g++) begin : g_blk
        assign bad_o[g] = (cnt_q[g] >= CW'(WEAR_LIMIT));

        always_ff @(posedge clk_i) begin
            if (rst_i) cnt_q[g] <= '0;
            else if (inc_i && blk_i == PB_W'(g) && !bad_o[g]) cnt_q[g] <= cnt_q[g] + 1'b1;
        end

        AST_WEAR_STILL: assert property (@(posedge clk_i) disable iff (rst_i)
            !(inc_i && blk_i == PB_W'(g)) |=> $stable(cnt_q[g])); // R6
        AST_BAD_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
            bad_o[g] |=> bad_o[g]); // R6
    end
endmodule

// File: rtl/fpm_page_manager.sv
module fpm_page_manager
    import fpm_pkg::*;
#(
    parameter int NUM_LBLK      = 3,
    parameter int NUM_SPARE     = 1,
    parameter int PAGES_PER_BLK = 32,
    parameter int DATA_W        = 8,
    parameter int ERASE_CYCLES  = 50000,
    parameter int WEAR_LIMIT    = 100000,
    localparam int NUM_PBLK = NUM_LBLK + NUM_SPARE,
    localparam int LB_W     = $clog2(NUM_LBLK),
    localparam int PB_W     = $clog2(NUM_PBLK),
    localparam int PG_W     = $clog2(PAGES_PER_BLK),
    localparam int DEPTH    = NUM_PBLK * PAGES_PER_BLK,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [LB_W-1:0]   req_lblk_i,
    input  logic [PG_W-1:0]   req_page_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              flash_erase_o,
    output logic [PB_W-1:0]   flash_erase_blk_o,
    output logic              flash_busy_o
);
    typedef struct packed {
        logic              wr;
        logic [LB_W-1:0]   lblk;
        logic [PG_W-1:0]   page;
        logic [DATA_W-1:0] data;
    } req_t;

    function automatic logic [IDX_W-1:0] fidx(logic [PB_W-1:0] b, logic [PG_W-1:0] p);
        return IDX_W'(int'(b) * PAGES_PER_BLK + int'(p));
    endfunction

    fsm_e              st_q;
    req_t              rq_q;
    page_state_e       pst_q [DEPTH];
    logic [PB_W-1:0]   map_q [NUM_LBLK];
    logic [PB_W-1:0]   old_q, spr_q;
    logic [PG_W-1:0]   idx_q;
    logic              done_q, err_q, erase_q;
    logic [DATA_W-1:0] rdata_q;

    logic [PB_W-1:0]     cur_pb;
    logic [IDX_W-1:0]    cur_ix;
    logic [NUM_PBLK-1:0] used, wear_bad;
    logic                spare_found;
    logic [PB_W-1:0]     spare_idx;
    logic                mem_we;
    logic [IDX_W-1:0]    mem_waddr, mem_raddr;
    logic [DATA_W-1:0]   mem_wdata, mem_rdata;
    logic                tmr_start, tmr_busy, tmr_fin;

    assign cur_pb = map_q[rq_q.lblk];
    assign cur_ix = fidx(cur_pb, rq_q.page);

    always_comb begin
        used = '0;
        for (int l = 0; l < NUM_LBLK; l++) used[map_q[l]] = 1'b1;
    end

    // lowest-numbered unmapped, unretired block wins
    always_comb begin
        spare_found = 1'b0;
        spare_idx   = '0;
        for (int i = NUM_PBLK - 1; i >= 0; i--) begin
            if (!used[i] && !wear_bad[i]) begin
                spare_found = 1'b1;
                spare_idx   = PB_W'(i);
            end
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = cur_ix;
        mem_wdata = rq_q.data;
        mem_raddr = cur_ix;
        if (st_q == ST_EXEC) begin
            mem_we = rq_q.wr && (pst_q[cur_ix] == PG_ERASED);
        end else if (st_q == ST_COPY) begin
            mem_raddr = fidx(old_q, idx_q);
            mem_waddr = fidx(spr_q, idx_q);
            if (idx_q == rq_q.page) begin
                mem_we = 1'b1;
            end else if (pst_q[mem_raddr] == PG_VALID) begin
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
            end
        end
    end

    assign tmr_start = (st_q == ST_EXEC) && rq_q.wr &&
                       (pst_q[cur_ix] != PG_ERASED) && spare_found;

    fpm_page_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk_i   (clk_i),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

    fpm_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (tmr_start),
        .busy_o  (tmr_busy),
        .fin_o   (tmr_fin)
    );

    fpm_wear_track #(.NUM_PBLK(NUM_PBLK), .WEAR_LIMIT(WEAR_LIMIT)) u_wear (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .inc_i (tmr_fin),
        .blk_i (spr_q),
        .bad_o (wear_bad)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q    <= ST_IDLE;
            rq_q    <= '0;
            old_q   <= '0;
            spr_q   <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            erase_q <= 1'b0;
            rdata_q <= '0;
            for (int l = 0; l < NUM_LBLK; l++) map_q[l] <= PB_W'(l);
            for (int i = 0; i < DEPTH; i++) pst_q[i] <= PG_ERASED;
        end else begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            erase_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        rq_q <= '{wr: req_write_i, lblk: req_lblk_i,
                                  page: req_page_i, data: req_wdata_i};
                        st_q <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (!rq_q.wr) begin
                        rdata_q <= (pst_q[cur_ix] == PG_VALID) ? mem_rdata : '1;
                        done_q  <= 1'b1;
                        st_q    <= ST_IDLE;
                    end else if (pst_q[cur_ix] == PG_ERASED) begin
                        pst_q[cur_ix] <= PG_VALID;
                        done_q        <= 1'b1;
                        st_q          <= ST_IDLE;
                    end else if (!spare_found) begin
                        err_q  <= 1'b1;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        old_q   <= cur_pb;
                        spr_q   <= spare_idx;
                        erase_q <= 1'b1;
                        st_q    <= ST_ERASE;
                    end
                end
                ST_ERASE: begin
                    if (tmr_fin) begin
                        for (int p = 0; p < PAGES_PER_BLK; p++)
                            pst_q[fidx(spr_q, PG_W'(p))] <= PG_ERASED;
                        idx_q <= '0;
                        st_q  <= ST_COPY;
                    end
                end
                ST_COPY: begin
                    if (pst_q[mem_raddr] == PG_VALID) pst_q[mem_raddr] <= PG_STALE;
                    if (mem_we) pst_q[mem_waddr] <= PG_VALID;
                    if (idx_q == PG_W'(PAGES_PER_BLK - 1)) st_q <= ST_FINISH;
                    else idx_q <= idx_q + 1'b1;
                end
                ST_FINISH: begin
                    map_q[rq_q.lblk] <= spr_q;
                    done_q           <= 1'b1;
                    st_q             <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready_o       = (st_q == ST_IDLE);
    assign done_o            = done_q;
    assign err_o             = err_q;
    assign rdata_o           = rdata_q;
    assign flash_erase_o     = erase_q;
    assign flash_erase_blk_o = spr_q;
    assign flash_busy_o      = tmr_busy;

    AST_PROG_ERASED_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_we |-> pst_q[mem_waddr] == PG_ERASED); // R3
    AST_ERASE_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        flash_erase_o |-> flash_busy_o); // R5
    AST_SPARE_RETIRED: assert property (@(posedge clk_i) disable iff (rst_i)
        flash_erase_o |-> !wear_bad[flash_erase_blk_o]); // R6
    AST_SPARE_UNMAPPED: assert property (@(posedge clk_i) disable iff (rst_i)
        flash_erase_o |-> !used[flash_erase_blk_o]); // R11
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o); // R9
    AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |-> done_o); // R9
    AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        req_valid_i && req_ready_o |=> !req_ready_o); // R9
endmodule

// File: tb/fpm_page_manager_tb.sv
module fpm_page_manager_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 3;
    localparam int NS = 1;
    localparam int NP = NL + NS;
    localparam int PG = 32;
    localparam int EC = 16;
    localparam int WL = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [1:0] req_lblk = '0;
    logic [4:0] req_page = '0;
    logic [7:0] req_wdata = '0;
    logic       done, err;
    logic [7:0] rdata;
    logic       f_erase;
    logic [1:0] f_blk;
    logic       f_busy;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] exp_d [NL][PG];
    bit         wr_f  [NL][PG];
    int         mp    [NL];
    int         cnt   [NP];
    bit         bad   [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    fpm_page_manager #(
        .NUM_LBLK(NL), .NUM_SPARE(NS), .PAGES_PER_BLK(PG), .DATA_W(8),
        .ERASE_CYCLES(EC), .WEAR_LIMIT(WL)
    ) dut_i (
        .clk_i(clk), .rst_i(rst),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
        .req_lblk_i(req_lblk), .req_page_i(req_page), .req_wdata_i(req_wdata),
        .done_o(done), .err_o(err), .rdata_o(rdata),
        .flash_erase_o(f_erase), .flash_erase_blk_o(f_blk), .flash_busy_o(f_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input int l, input int p, input logic [7:0] d,
                          output logic [7:0] rd, output bit e, output int n_er,
                          output int eblk, output int n_busy, output int n_done);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_lblk = 2'(l);
        req_page = 5'(p); req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n_er = 0; eblk = -1; n_busy = 0; n_done = 0; e = 0; rd = '0;
        for (int k = 0; k < 400; k++) begin
            if (f_erase) begin n_er++; eblk = int'(f_blk); end
            if (f_busy) n_busy++;
            if (done) begin n_done++; rd = rdata; e = err; break; end
            @(negedge clk);
        end
        @(negedge clk);
        if (done) n_done++;
    endtask

    task automatic rd_chk(input int l, input int p, input string req);
        logic [7:0] rd; bit e; int a, b, c, nd;
        do_req(1'b0, l, p, 8'h00, rd, e, a, b, c, nd);
        check(nd == 1 && !e, "R9 read completion", nd, 1);
        check(rd == exp_d[l][p], req, int'(rd), int'(exp_d[l][p]));
    endtask

    task automatic wr_chk(input int l, input int p, input logic [7:0] d);
        logic [7:0] rd; bit e; int ner, eb, nb, nd;
        int sp;
        do_req(1'b1, l, p, d, rd, e, ner, eb, nb, nd);
        check(nd == 1, "R9 one done pulse", nd, 1);
        if (!wr_f[l][p]) begin
            check(!e && ner == 0, "R3 direct program", ner, 0);
            wr_f[l][p] = 1; exp_d[l][p] = d;
        end else begin
            sp = -1;
            for (int b = NP - 1; b >= 0; b--) begin
                bit inuse = 0;
                for (int q = 0; q < NL; q++) if (mp[q] == b) inuse = 1;
                if (!inuse && !bad[b]) sp = b;
            end
            if (sp < 0) begin
                check(e == 1, "R7 no spare error", int'(e), 1);
                check(ner == 0, "R7 no erase issued", ner, 0);
            end else begin
                check(e == 0, "R4 relocation no error", int'(e), 0);
                check(ner == 1, "R5 one erase pulse", ner, 1);
                check(eb == sp, "R11 spare choice", eb, sp);
                check(nb == EC, "R5 busy length", nb, EC);
                cnt[sp]++;
                if (cnt[sp] >= WL) bad[sp] = 1;
                mp[l] = sp; exp_d[l][p] = d;
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        for (int l = 0; l < NL; l++) begin
            mp[l] = l;
            for (int p = 0; p < PG; p++) begin exp_d[l][p] = 8'hFF; wr_f[l][p] = 0; end
        end
        for (int b = 0; b < NP; b++) begin cnt[b] = 0; bad[b] = 0; end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
        check(done == 1'b0 && f_busy == 1'b0, "R10 idle outputs", int'(done), 0);

        // R8 R10: fresh pages read as all ones
        for (int l = 0; l < NL; l++)
            for (int p = 0; p < PG; p++) rd_chk(l, p, "R8 erased read");

        // R2 R3: fill blocks 1,2 fully, block 0 only even pages
        for (int l = 0; l < NL; l++)
            for (int p = 0; p < PG; p++)
                if (l != 0 || p % 2 == 0) wr_chk(l, p, 8'((l * 37 + p * 5 + 1) & 8'hFF));
        for (int l = 0; l < NL; l++)
            for (int p = 0; p < PG; p++) rd_chk(l, p, "R1 R2 sweep readback");

        // R4 R5 R6 R11: rewrite one page until spares are exhausted (R7)
        for (int n = 0; n < 2 * WL + 1; n++) begin
            wr_chk(0, 4, 8'(8'hA0 + n));
            for (int p = 0; p < PG; p++) rd_chk(0, p, "R4 R1 data after relocation");
        end
        wr_chk(1, 7, 8'h5A);
        for (int p = 0; p < PG; p++) rd_chk(1, p, "R7 data unchanged after refusal");

        // R3: erased page in a retired but mapped block is still programmable
        wr_chk(0, 9, 8'h3C);
        rd_chk(0, 9, "R3 late program readback");
        rd_chk(0, 11, "R8 untouched odd page");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule